// File: doc/BRIEF.md
# Load Ordering Queue with Violation Search

This block keeps the in-flight loads of one thread in program order inside a circular buffer. It also watches for loads that ran ahead of an older memory operation to the same address. A load is allocated at dispatch and gets a slot index back. Later the load reports its resolved address against that index. When a store, or an older load, resolves its own address, it issues a check. The check carries the queue position where the search starts and the address to compare. The block then searches the younger loads that already hold an address. If one of them falls in the same coarse address block, the oldest such load is latched as the pending violator. The pipeline can then refetch from that load onward.

Commit retires loads from the head up to a given youngest sequence number. Squash discards loads from the tail that are younger than a given sequence number. A squash also drops the pending violator once that violator is itself squashed. The violator register is read-and-clear: a read pulse consumes the value shown on the outputs. The block does not return data, forward values or access the cache.

Top module: `lq_order_check`

## Requirements
- R1: The queue holds DEPTH loads in DEPTH+1 slots. `alloc_ready` is low exactly when DEPTH loads are held, and an allocation attempted then is dropped. `alloc_idx` shows the tail slot. Each accepted allocation advances the tail by one, and the tail wraps from slot DEPTH to slot 0.
- R2: Each allocation records a store-queue tag. The tag is the given store-queue tail, or -1 (all ones on the SQ_IW+1 bit `peek_sq_tag`) when `alloc_sq_empty` is high. `peek_idx` reads the tag back.
- R3: An allocated slot starts without a valid address. An address update makes the address of that held load valid. A slot reused after a squash therefore never matches on its old address.
- R4: A store check (`chk_is_load`=0) searches from `chk_idx` up to the current tail, tail excluded, in ring order. When `chk_idx` equals the tail, the search finds nothing.
- R5: A load check (`chk_is_load`=1) starts at the slot after `chk_idx`, with wrap, and ends before the tail.
- R6: A load matches only when its address is valid and its address equals the check address once the low BLK_SHIFT bits (default 8) are dropped.
- R7: Only the first match in program order counts. It becomes the pending violator when none is pending or when its sequence number is smaller. Otherwise the pending violator stays as it was.
- R8: Commit removes loads from the head while the queue holds any load and the head load's sequence number is at most `commit_seq`.
- R9: Squash removes loads from the tail backward while their sequence number exceeds `squash_seq`. The tail steps back through slot 0 to slot DEPTH.
- R10: A squash clears the pending violator when the violator's sequence number exceeds `squash_seq`, and keeps it otherwise.
- R11: `viol_seq` and `viol_pending` show the pending violator. `viol_rd` empties the register at the clock edge. A match found by a check in the same cycle becomes the new pending violator whatever its age.
- R12: In a cycle with `squash_valid` high, allocation, commit and check are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tail | input | SQ_IW | Store-queue tail at allocation |
| alloc_sq_empty | input | 1 | Store queue empty at allocation |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IW | Slot the next allocation takes |
| addr_valid | input | 1 | Address-resolved update |
| addr_idx | input | IW | Slot of the resolved load |
| addr_val | input | ADDR_W | Resolved address |
| chk_valid | input | 1 | Ordering check request |
| chk_is_load | input | 1 | 1: check from an older load, 0: from a store |
| chk_idx | input | IW | Load's own slot, or store's recorded tail |
| chk_addr | input | ADDR_W | Address of the checking operation |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| viol_rd | input | 1 | Consume the pending violator |
| viol_pending | output | 1 | A violator is pending |
| viol_seq | output | SEQ_W | Sequence number of the pending violator |
| peek_idx | input | IW | Slot whose store-queue tag is shown |
| peek_sq_tag | output | SQ_IW+1 | Recorded store-queue tag, signed |
| lq_count | output | CW | Number of loads held |

## Verification
The search is exercised with store checks and load checks. Some cover a match in the first slot searched, some a match behind a slot with no address, and some a range that wraps past the last slot. These separate the store start rule from the load start rule and show that the oldest match wins over later ones. Address pairs that differ only below bit 8, and pairs that differ just above it, probe the block granularity. Sequences of pending younger and older violators, mixed with squashes, commits and reads that land in the same cycle as a check, show whether the violator register keeps, replaces or clears its value as required.

// File: rtl/lq_pkg.sv
package lq_pkg;
   // Ring helpers: indices are below n
   function automatic int ring_add(int a, int b, int n);
      return (a + b) % n;
   endfunction

   function automatic int ring_dist(int to_i, int from_i, int n);
      return (to_i - from_i + n) % n;
   endfunction
endpackage

// File: rtl/lq_ring_ptr.sv
module lq_ring_ptr #(
   parameter int SLOTS = 5,
   localparam int IW = $clog2(SLOTS),
   localparam int CW = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          do_alloc,
   input  logic [CW-1:0] n_commit,
   input  logic [CW-1:0] n_squash,
   output logic [IW-1:0] head,
   output logic [IW-1:0] tail,
   output logic [CW-1:0] count
);
   import lq_pkg::*;

   logic [IW-1:0] head_n, tail_n;
   logic [CW-1:0] count_n;

   always_comb begin
      head_n  = IW'(ring_add(int'(head), int'(n_commit), SLOTS));
      tail_n  = IW'(ring_add(ring_dist(int'(tail), int'(n_squash), SLOTS),
                             int'(do_alloc), SLOTS));
      count_n = CW'(int'(count) + int'(do_alloc) - int'(n_commit) - int'(n_squash));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head  <= head_n;
         tail  <= tail_n;
         count <= count_n;
      end
   end
endmodule

// File: rtl/lq_scan.sv
module lq_scan #(
   parameter int SLOTS     = 5,
   parameter int SEQ_W     = 8,
   parameter int ADDR_W    = 16,
   parameter int BLK_SHIFT = 8,
   localparam int IW = $clog2(SLOTS)
) (
   input  logic              occ     [SLOTS],
   input  logic              av      [SLOTS],
   input  logic [ADDR_W-1:0] addr    [SLOTS],
   input  logic [SEQ_W-1:0]  seq     [SLOTS],
   input  logic [IW-1:0]     start,
   input  logic [IW-1:0]     tail,
   input  logic [ADDR_W-1:0] key,
   output logic              hit,
   output logic [SEQ_W-1:0]  hit_seq
);
   import lq_pkg::*;

   // Walk slots in program order from start; the first hit wins
   always_comb begin
      int span;
      hit     = 1'b0;
      hit_seq = '0;
      span    = ring_dist(int'(tail), int'(start), SLOTS);
      for (int k = 0; k < SLOTS; k++) begin
         int idx;
         idx = ring_add(int'(start), k, SLOTS);
         if (!hit && k < span && occ[idx] && av[idx] &&
             ((addr[idx] >> BLK_SHIFT) == (key >> BLK_SHIFT))) begin
            hit     = 1'b1;
            hit_seq = seq[idx];
         end
      end
   end
endmodule

// File: rtl/lq_viol_hold.sv
module lq_viol_hold #(
   parameter int SEQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic             hit,
   input  logic [SEQ_W-1:0] hit_seq,
   input  logic             squash,
   input  logic [SEQ_W-1:0] squash_seq,
   output logic             pend,
   output logic [SEQ_W-1:0] pend_seq
);
   logic drop;

   always_comb drop = rd || (squash && pend && (pend_seq > squash_seq));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         pend_seq <= '0;
      end else if (drop) begin
         pend <= hit;
         if (hit) pend_seq <= hit_seq;
      end else if (hit && (!pend || hit_seq < pend_seq)) begin
         pend     <= 1'b1;
         pend_seq <= hit_seq;
      end
   end
endmodule

// File: rtl/lq_order_check.sv
module lq_order_check #(
   parameter int DEPTH     = 4,
   parameter int SEQ_W     = 8,
   parameter int ADDR_W    = 16,
   parameter int BLK_SHIFT = 8,
   parameter int SQ_IW     = 3,
   localparam int SLOTS = DEPTH + 1,
   localparam int IW    = $clog2(SLOTS),
   localparam int CW    = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [SEQ_W-1:0]  alloc_seq,
   input  logic [SQ_IW-1:0]  alloc_sq_tail,
   input  logic              alloc_sq_empty,
   output logic              alloc_ready,
   output logic [IW-1:0]     alloc_idx,
   input  logic              addr_valid,
   input  logic [IW-1:0]     addr_idx,
   input  logic [ADDR_W-1:0] addr_val,
   input  logic              chk_valid,
   input  logic              chk_is_load,
   input  logic [IW-1:0]     chk_idx,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic              commit_valid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              squash_valid,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic              viol_rd,
   output logic              viol_pending,
   output logic [SEQ_W-1:0]  viol_seq,
   input  logic [IW-1:0]     peek_idx,
   output logic signed [SQ_IW:0] peek_sq_tag,
   output logic [CW-1:0]     lq_count
);
   import lq_pkg::*;

   if (DEPTH < 2)               $error("DEPTH must be at least 2");
   if (BLK_SHIFT >= ADDR_W)     $error("BLK_SHIFT must be below ADDR_W");
   if (SEQ_W < 2 || SQ_IW < 1)  $error("SEQ_W and SQ_IW too small");

   logic [IW-1:0]     head, tail;
   logic [CW-1:0]     count;
   logic              occ     [SLOTS];
   logic              av_q    [SLOTS];
   logic [ADDR_W-1:0] addr_q  [SLOTS];
   logic [SEQ_W-1:0]  seq_q   [SLOTS];
   logic [SQ_IW:0]    tag_q   [SLOTS];
   logic [CW-1:0]     n_commit, n_squash;
   logic              do_alloc, do_chk;
   logic [IW-1:0]     scan_start;
   logic              hit_raw, hit;
   logic [SEQ_W-1:0]  hit_seq;

   assign alloc_ready = (int'(count) < DEPTH);
   assign alloc_idx   = tail;
   assign lq_count    = count;
   assign do_alloc    = alloc_valid && alloc_ready && !squash_valid;
   assign do_chk      = chk_valid && !squash_valid;
   assign hit         = hit_raw && do_chk;
   assign peek_sq_tag = signed'(tag_q[peek_idx]);

   // Occupancy and the commit / squash removal counts
   always_comb begin
      int nc, ns;
      nc = 0;
      ns = 0;
      for (int i = 0; i < SLOTS; i++) begin
         occ[i] = ring_dist(i, int'(head), SLOTS) < int'(count);
         if (occ[i] && seq_q[i] <= commit_seq) nc++;
         if (occ[i] && seq_q[i] >  squash_seq) ns++;
      end
      n_commit = (commit_valid && !squash_valid) ? CW'(nc) : '0;
      n_squash = squash_valid ? CW'(ns) : '0;
   end

   always_comb begin
      if (chk_is_load) scan_start = IW'(ring_add(int'(chk_idx), 1, SLOTS));
      else             scan_start = chk_idx;
   end

   // Per-slot entry storage
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            av_q[s]   <= 1'b0;
            addr_q[s] <= '0;
            seq_q[s]  <= '0;
            tag_q[s]  <= '0;
         end else if (do_alloc && tail == IW'(s)) begin
            av_q[s]  <= 1'b0;
            seq_q[s] <= alloc_seq;
            tag_q[s] <= alloc_sq_empty ? '1 : {1'b0, alloc_sq_tail};
         end else if (addr_valid && addr_idx == IW'(s) && occ[s]) begin
            av_q[s]   <= 1'b1;
            addr_q[s] <= addr_val;
         end
      end
   end

   lq_ring_ptr #(.SLOTS(SLOTS)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_alloc (do_alloc),
      .n_commit (n_commit),
      .n_squash (n_squash),
      .head     (head),
      .tail     (tail),
      .count    (count)
   );

   lq_scan #(
      .SLOTS(SLOTS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)
   ) u_scan (
      .occ     (occ),
      .av      (av_q),
      .addr    (addr_q),
      .seq     (seq_q),
      .start   (scan_start),
      .tail    (tail),
      .key     (chk_addr),
      .hit     (hit_raw),
      .hit_seq (hit_seq)
   );

   lq_viol_hold #(.SEQ_W(SEQ_W)) u_viol (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (viol_rd),
      .hit        (hit),
      .hit_seq    (hit_seq),
      .squash     (squash_valid),
      .squash_seq (squash_seq),
      .pend       (viol_pending),
      .pend_seq   (viol_seq)
   );
endmodule

// File: rtl/lq_order_check_sva.sv
module lq_order_check_sva #(
   parameter int DEPTH = 4,
   parameter int SEQ_W = 8,
   parameter int CW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             alloc_ready,
   input logic             chk_valid,
   input logic             commit_valid,
   input logic             squash_valid,
   input logic [SEQ_W-1:0] squash_seq,
   input logic             viol_rd,
   input logic             viol_pending,
   input logic [SEQ_W-1:0] viol_seq,
   input logic [CW-1:0]    lq_count
);
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lq_count) <= DEPTH);

   p_full_no_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_ready |=> lq_count <= $past(lq_count));

   p_commit_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && !alloc_valid) |=> lq_count <= $past(lq_count));

   p_squash_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> lq_count <= $past(lq_count));

   p_squash_drops_viol_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_valid && viol_pending && viol_seq > squash_seq) |=> !viol_pending);

   p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_rd && !chk_valid) |=> !viol_pending);

   p_hold_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pending && !viol_rd && !chk_valid && !squash_valid)
      |=> (viol_pending && $stable(viol_seq)));

   p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!viol_pending && (!chk_valid || squash_valid)) |=> !viol_pending);
endmodule

bind lq_order_check lq_order_check_sva #(
   .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CW(CW)
) u_sva (.*);

// File: tb/sim_lq_order_check.sv
module sim_lq_order_check;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        alloc_valid = 0, alloc_sq_empty = 0, addr_valid = 0;
   logic        chk_valid = 0, chk_is_load = 0, commit_valid = 0;
   logic        squash_valid = 0, viol_rd = 0;
   logic [7:0]  alloc_seq = 0, commit_seq = 0, squash_seq = 0;
   logic [2:0]  alloc_sq_tail = 0, addr_idx = 0, chk_idx = 0, peek_idx = 0;
   logic [15:0] addr_val = 0, chk_addr = 0;
   logic        alloc_ready, viol_pending;
   logic [2:0]  alloc_idx, lq_count;
   logic [7:0]  viol_seq;
   logic signed [3:0] peek_sq_tag;

   lq_order_check u0 (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   localparam int OP_ALLOC = 0, OP_ADDR = 1, OP_CHKS = 2, OP_CHKL = 3,
                  OP_COMMIT = 4, OP_SQUASH = 5, OP_READ = 6;

   function automatic logic [47:0] mk(int op, int a, int b, int pre, int cnt, int p, int vs);
      return {3'(op), 8'(a), 16'(b), 8'(pre), 4'(cnt), 1'(p), 8'(vs)};
   endfunction

   localparam int NV = 28;
   localparam logic [47:0] TBL [NV] = '{
      mk(OP_ALLOC, 10, 0, 0, 1, 0, 0),
      mk(OP_ALLOC, 11, 0, 1, 2, 0, 0),
      mk(OP_ALLOC, 12, 0, 2, 3, 0, 0),
      mk(OP_ALLOC, 13, 0, 3, 4, 0, 0),
      mk(OP_ADDR, 1, 16'h1234, 0, 4, 0, 0),
      mk(OP_ADDR, 3, 16'h12FF, 0, 4, 0, 0),
      mk(OP_CHKS, 0, 16'h1200, 0, 4, 1, 11),
      mk(OP_CHKL, 2, 16'h1250, 0, 4, 1, 11),
      mk(OP_READ, 0, 0, 11, 4, 0, 0),
      mk(OP_CHKL, 2, 16'h12AA, 0, 4, 1, 13),
      mk(OP_CHKS, 0, 16'h1300, 0, 4, 1, 13),
      mk(OP_SQUASH, 12, 0, 0, 3, 0, 0),
      mk(OP_CHKL, 0, 16'h1234, 0, 3, 1, 11),
      mk(OP_COMMIT, 10, 0, 0, 2, 1, 11),
      mk(OP_SQUASH, 11, 0, 0, 1, 1, 11),
      mk(OP_ALLOC, 20, 0, 2, 2, 1, 11),
      mk(OP_ALLOC, 21, 0, 3, 3, 1, 11),
      mk(OP_ALLOC, 22, 0, 4, 4, 1, 11),
      mk(OP_COMMIT, 11, 0, 0, 3, 1, 11),
      mk(OP_ALLOC, 23, 0, 0, 4, 1, 11),
      mk(OP_ADDR, 0, 16'h4400, 0, 4, 1, 11),
      mk(OP_ADDR, 3, 16'h4480, 0, 4, 1, 11),
      mk(OP_READ, 0, 0, 11, 4, 0, 0),
      mk(OP_CHKS, 2, 16'h44FF, 0, 4, 1, 21),
      mk(OP_READ, 0, 0, 21, 4, 0, 0),
      mk(OP_CHKL, 4, 16'h4401, 0, 4, 1, 23),
      mk(OP_SQUASH, 19, 0, 0, 0, 0, 0),
      mk(OP_COMMIT, 50, 0, 0, 0, 0, 0)
   };

   task automatic idle();
      alloc_valid = 0; addr_valid = 0; chk_valid = 0; commit_valid = 0;
      squash_valid = 0; viol_rd = 0;
   endtask

   // Drive one operation after a falling edge; returns after the rising edge
   task automatic apply(input int op, input int a, input int b, input int pre, input string tag);
      @(negedge clk);
      case (op)
         OP_ALLOC:  begin alloc_valid = 1; alloc_seq = 8'(a); end
         OP_ADDR:   begin addr_valid = 1; addr_idx = 3'(a); addr_val = 16'(b); end
         OP_CHKS:   begin chk_valid = 1; chk_is_load = 0; chk_idx = 3'(a); chk_addr = 16'(b); end
         OP_CHKL:   begin chk_valid = 1; chk_is_load = 1; chk_idx = 3'(a); chk_addr = 16'(b); end
         OP_COMMIT: begin commit_valid = 1; commit_seq = 8'(a); end
         OP_SQUASH: begin squash_valid = 1; squash_seq = 8'(a); end
         OP_READ:   viol_rd = 1;
         default: ;
      endcase
      #1;
      if (op == OP_ALLOC) check(alloc_idx == 3'(pre), {tag, " alloc_idx"}, alloc_idx, pre);
      if (op == OP_READ)  check(viol_pending && viol_seq == 8'(pre), {tag, " read value"}, viol_seq, pre);
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic post(input string tag, input int cnt, input int p, input int vs);
      check(lq_count == 3'(cnt), {tag, " count"}, lq_count, cnt);
      check(viol_pending == 1'(p), {tag, " pending"}, viol_pending, p);
      if (p != 0) check(viol_seq == 8'(vs), {tag, " violator"}, viol_seq, vs);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(lq_count == 0, "R1 reset count", lq_count, 0);
      check(alloc_ready == 1, "R1 reset ready", alloc_ready, 1);
      check(alloc_idx == 0, "R1 reset tail", alloc_idx, 0);
      check(viol_pending == 0, "R11 reset pending", viol_pending, 0);

      // Vector walk: R1 R3 R4 R5 R6 R7 R8 R9 R10 R11
      for (int v = 0; v < NV; v++) begin
         logic [47:0] r;
         string tg;
         r = TBL[v];
         case (int'(r[47:45]))
            OP_ALLOC:  tg = "R1";
            OP_ADDR:   tg = "R3";
            OP_CHKS:   tg = "R4/R7";
            OP_CHKL:   tg = "R5/R7";
            OP_COMMIT: tg = "R8";
            OP_SQUASH: tg = "R9/R10";
            default:   tg = "R11";
         endcase
         tg = $sformatf("%s v%0d", tg, v);
         apply(int'(r[47:45]), int'(r[44:37]), int'(r[36:21]), int'(r[20:13]), tg);
         post(tg, int'(r[12:9]), int'(r[8]), int'(r[7:0]));
      end
      // queue now empty, head = tail = 2

      // R2 store-queue tag recording, R1 fill to capacity
      @(negedge clk); alloc_sq_empty = 1;
      apply(OP_ALLOC, 30, 0, 2, "R1 fill");
      @(negedge clk); alloc_sq_empty = 0; alloc_sq_tail = 5;
      apply(OP_ALLOC, 31, 0, 3, "R1 fill");
      apply(OP_ALLOC, 32, 0, 4, "R1 fill");
      apply(OP_ALLOC, 33, 0, 0, "R1 fill wrap");
      @(negedge clk); peek_idx = 2; #1;
      check(peek_sq_tag == -4'sd1, "R2 empty tag", peek_sq_tag, -1);
      peek_idx = 3; #1;
      check(peek_sq_tag == 4'sd5, "R2 tail tag", peek_sq_tag, 5);
      check(alloc_ready == 0, "R1 full ready", alloc_ready, 0);
      apply(OP_ALLOC, 34, 0, 1, "R1 full");
      check(lq_count == 4, "R1 dropped alloc", lq_count, 4);
      check(alloc_idx == 1, "R1 tail kept", alloc_idx, 1);

      // R3: slot 3 held 0x4480 before; reallocated so no match
      apply(OP_CHKS, 2, 16'h4480, 0, "R3");
      check(viol_pending == 0, "R3 stale address", viol_pending, 0);

      // R4: start equal to tail gives an empty range
      apply(OP_ADDR, 0, 16'h5500, 0, "R6");
      apply(OP_CHKS, 1, 16'h5500, 0, "R4");
      check(viol_pending == 0, "R4 empty range", viol_pending, 0);

      // R6: neighbouring block does not match, low bits ignored
      apply(OP_CHKS, 2, 16'h5600, 0, "R6");
      check(viol_pending == 0, "R6 other block", viol_pending, 0);
      apply(OP_CHKS, 2, 16'h5501, 0, "R6");
      post("R6 same block", 4, 1, 33);

      // R12: squash with a check and a commit in the same cycle
      apply(OP_READ, 0, 0, 33, "R11");
      @(negedge clk);
      squash_valid = 1; squash_seq = 31;
      chk_valid = 1; chk_is_load = 0; chk_idx = 2; chk_addr = 16'h5500;
      commit_valid = 1; commit_seq = 40;
      alloc_valid = 1; alloc_seq = 60;
      @(posedge clk); #1; idle();
      post("R12 squash wins", 2, 0, 0);
      check(alloc_idx == 4, "R12 tail after squash", alloc_idx, 4);

      // R11: read with a same-cycle match installs the new violator
      apply(OP_ADDR, 3, 16'h6600, 0, "R3");
      apply(OP_CHKS, 2, 16'h6600, 0, "R7");
      post("R7 first", 2, 1, 31);
      @(negedge clk);
      viol_rd = 1; chk_valid = 1; chk_is_load = 0; chk_idx = 3; chk_addr = 16'h6600;
      #1 check(viol_seq == 31, "R11 read value", viol_seq, 31);
      @(posedge clk); #1; idle();
      post("R11 read plus match", 2, 1, 31);

      // R7: older match replaces a younger pending violator
      apply(OP_READ, 0, 0, 31, "R11");
      apply(OP_ALLOC, 34, 0, 4, "R1");
      apply(OP_ADDR, 4, 16'h66C0, 0, "R3");
      apply(OP_CHKL, 3, 16'h6600, 0, "R5");
      post("R7 younger", 3, 1, 34);
      apply(OP_CHKS, 2, 16'h6610, 0, "R7");
      post("R7 older replaces", 3, 1, 31);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule